// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned W-bit operands, W being 32 by default, and produces a 2W-bit product. It works one multiplier bit per clock. It keeps a single 2W-bit product register and one W-bit multiplicand register. The multiplier operand is not held in a register of its own. It is loaded into the low half of the product register and is used up from the bottom as the partial sum moves in from the top.

Each step examines bit 0 of the product register. When that bit is 1, a W-bit adder adds the stored multiplicand to the upper half. In the same clock the register shifts right by one place, and the carry out of the adder enters at the top. After exactly W steps the upper half of the register holds the high word of the product and the lower half holds the low word.

A caller pulses the start input for one clock while the unit is idle. It then waits for the single-cycle completion pulse and reads the product from the two halves. The result stays on the outputs until the next accepted start.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are 0, and hi and lo are 0 until the first accepted start.
- R2: A start seen at a clock edge while busy is 0 is accepted. After that edge busy is 1, hi is 0 and lo equals the multiplier input sampled at that edge.
- R3: On each step, if bit 0 of the {hi,lo} register is 1, the multiplicand is added to hi. The register then shifts right by one bit with the adder carry entering bit 2W-1. For multiplicand 5 and multiplier 3 with W=32, the first step leaves hi=0x00000002 and lo=0x80000001.
- R4: Busy stays 1 for exactly W clock cycles after the accepted start edge.
- R5: Done is 1 for exactly one cycle. That cycle immediately follows the last step, and busy is 0 during it.
- R6: In the done cycle, {hi,lo} equals the full 2W-bit unsigned product of the operands sampled at the accepted start, including when both operands are all ones.
- R7: A start asserted while busy is 1 is ignored. The running multiply finishes at its original time with its original result.
- R8: While busy is 0 and start is 0, hi and lo keep their values.
- R9: A start asserted in the done cycle is accepted, so multiplies can run back to back.
- R10: Changes on the operand inputs while busy is 1 and start is 0 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a multiply; accepted only when idle |
| mcand_i | input | W | Unsigned multiplicand |
| mplier_i | input | W | Unsigned multiplier |
| busy_o | output | 1 | A multiply is in progress |
| done_o | output | 1 | One-cycle pulse: product is valid |
| hi_o | output | W | Upper half of the product register |
| lo_o | output | W | Lower half of the product register |

## Verification
The bound checker checks the following on every cycle:
- busy and done are never high together;
- done lasts a single cycle;
- the first cycle after an accepted start holds a cleared upper half and the multiplier in the lower half;
- the result is held while the unit is idle;
- the busy period lasts exactly W cycles, counted by its own counter;
- every completion carries the exact product of the operands it captured.

Other behaviour can only be shown by the bench's scenarios. These are the intermediate value after one step, and ignored starts or operand changes in the middle of a run. They also include a start placed in the done cycle, and products at the operand extremes where the adder carry must reach bit 2W-1.

// File: rtl/shiftadd_mul_pkg.sv
// Package: shared types for the shift-add multiplier.
// Assumes nothing beyond standard SystemVerilog.
package shiftadd_mul_pkg;

    // Sequencer states: waiting for a start, or stepping through bits.
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/shiftadd_mul_adder.sv
// Module: W-bit unsigned adder with carry out.
// RIPPLE=1 builds an explicit full-adder chain; RIPPLE=0 leaves the
// structure to synthesis. Purely combinational; assumes W >= 1.
module shiftadd_mul_adder #(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         co_o
);

    generate
        if (RIPPLE) begin : g_ripple
            logic [W:0] carry;
            assign carry[0] = 1'b0;
            for (genvar k = 0; k < W; k++) begin : g_bit
                // One full-adder cell per bit position.
                assign sum_o[k]   = a_i[k] ^ b_i[k] ^ carry[k];
                assign carry[k+1] = (a_i[k] & b_i[k]) | (carry[k] & (a_i[k] ^ b_i[k]));
            end
            assign co_o = carry[W];
        end else begin : g_infer
            // Single wide addition; the extra bit is the carry.
            always_comb begin
                {co_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
            end
        end
    endgenerate

endmodule

// File: rtl/shiftadd_mul_ctrl.sv
// Module: sequencer for the shift-add multiplier.
// Accepts a start only in IDLE, then issues W step strobes and a one-cycle
// done pulse after the last step. Assumes W >= 2.
module shiftadd_mul_ctrl
    import shiftadd_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    seq_state_t    state_q;
    logic [CW-1:0] cnt_q;
    logic          last_step;

    assign load_o    = (state_q == SEQ_IDLE) && start_i;
    assign step_o    = (state_q == SEQ_RUN);
    assign busy_o    = (state_q == SEQ_RUN);
    assign last_step = step_o && (cnt_q == LAST);

    // State register: enter RUN on an accepted start, leave after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else if (load_o) begin
            state_q <= SEQ_RUN;
        end else if (last_step) begin
            state_q <= SEQ_IDLE;
        end
    end

    // Step counter: cleared on load, advanced on every step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_o) begin
            cnt_q <= '0;
        end else if (step_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Completion pulse: one cycle after the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
        end else begin
            done_o <= last_step;
        end
    end

endmodule

// File: rtl/shiftadd_mul_dpath.sv
// Module: datapath holding the multiplicand and the combined product/
// multiplier register. On load the multiplier goes to the low half and the
// high half is cleared; each step conditionally adds and shifts right.
// Assumes load and step are never asserted together.
module shiftadd_mul_dpath #(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);

    localparam int PW = 2 * W;

    logic [W-1:0]  mcand_q;
    logic [PW-1:0] prod_q;
    logic [W-1:0]  addend;
    logic [W-1:0]  sum;
    logic          carry;

    // Select the multiplicand or zero from the current low bit.
    always_comb begin
        addend = prod_q[0] ? mcand_q : '0;
    end

    shiftadd_mul_adder #(
        .W      (W),
        .RIPPLE (RIPPLE)
    ) adder_i (
        .a_i   (prod_q[PW-1:W]),
        .b_i   (addend),
        .sum_o (sum),
        .co_o  (carry)
    );

    // Multiplicand register: captured only on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
        end else if (load_i) begin
            mcand_q <= mcand_i;
        end
    end

    // Product register: load, or add-then-shift with carry into the top bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (load_i) begin
            prod_q <= {{W{1'b0}}, mplier_i};
        end else if (step_i) begin
            prod_q <= {carry, sum, prod_q[W-1:1]};
        end
    end

    assign hi_o = prod_q[PW-1:W];
    assign lo_o = prod_q[W-1:0];

endmodule

// File: rtl/shiftadd_mul.sv
// Module: top of the iterative unsigned multiplier.
// Start is taken only when idle; the product is valid in the done cycle and
// held until the next accepted start. Assumes W >= 2.
module shiftadd_mul #(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);

    logic load;
    logic step;

    shiftadd_mul_ctrl #(
        .W (W)
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    shiftadd_mul_dpath #(
        .W      (W),
        .RIPPLE (RIPPLE)
    ) dpath_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .hi_o     (hi_o),
        .lo_o     (lo_o)
    );

endmodule

// File: rtl/shiftadd_mul_chk.sv
// Module: property checker for shiftadd_mul, attached by bind.
// Observes ports only; keeps its own operand copy and busy-cycle counter.
module shiftadd_mul_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [W-1:0] mcand_i,
    input logic [W-1:0] mplier_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] hi_o,
    input logic [W-1:0] lo_o
);

    localparam int CNTW = $clog2(W) + 2;

    logic            accept;
    logic [CNTW-1:0] cyc_q;
    logic [2*W-1:0]  expect_q;

    assign accept = start_i && !busy_o;

    // Expected product captured from the operands at each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_q <= '0;
        end else if (accept) begin
            expect_q <= (2*W)'(mcand_i) * (2*W)'(mplier_i);
        end
    end

    // Busy-cycle counter restarted at each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (accept) begin
            cyc_q <= '0;
        end else if (busy_o) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // R5
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    load_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy_o && hi_o == '0 && lo_o == $past(mplier_i)));

    // R4
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cyc_q == CNTW'(W)));

    // R4
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cyc_q < CNTW'(W)));

    // R6
    result_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ({hi_o, lo_o} == expect_q));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable({hi_o, lo_o}));

endmodule

bind shiftadd_mul shiftadd_mul_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .hi_o     (hi_o),
    .lo_o     (lo_o)
);

// File: tb/shiftadd_mul_tb_top.sv
// Bench: vector table walked by one loop, then directed corner tests.
module shiftadd_mul_tb_top;

    localparam int W  = 32;
    localparam int NV = 8;

    // Each entry: {multiplicand, multiplier}.
    localparam logic [2*W-1:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h0000_0001, 32'hFFFF_FFFF},
        {32'hFFFF_FFFF, 32'h0000_0001},
        {32'h8000_0000, 32'h0000_0002},
        {32'h1234_5678, 32'h9ABC_DEF0},
        {32'h0000_0003, 32'h0000_0002},
        {32'h0000_FFFF, 32'h0001_0001}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] mcand_i = '0;
    logic [W-1:0] mplier_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] hi_o;
    logic [W-1:0] lo_o;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    shiftadd_mul #(.W(W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .hi_o     (hi_o),
        .lo_o     (lo_o)
    );

    task automatic chk(input bit ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts a multiply at the current negedge and waits for done.
    // With hold set, it also checks one idle cycle after done (R8).
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit hold);
        logic [2*W-1:0] exp = (2*W)'(a) * (2*W)'(b);
        int k = 0;
        start_i  = 1'b1;
        mcand_i  = a;
        mplier_i = b;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && hi_o == '0 && lo_o == b, "R2", {hi_o, lo_o}, {32'h0, b});
        while (!done_o && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk(k == W, "R4", 64'(k), 64'(W));
        chk(done_o && !busy_o, "R5", {62'h0, done_o, busy_o}, 64'h2);
        chk({hi_o, lo_o} == exp, "R6", {hi_o, lo_o}, exp);
        if (hold) begin
            @(negedge clk);
            chk(!done_o, "R5", 64'(done_o), 64'h0);
            chk({hi_o, lo_o} == exp, "R8", {hi_o, lo_o}, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [2*W-1:0] exp;
        int k;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk(!busy_o && !done_o && {hi_o, lo_o} == '0, "R1", {hi_o, lo_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && {hi_o, lo_o} == '0, "R1", {62'h0, busy_o, done_o}, 64'h0);

        // Vector table walk (R2, R4, R5, R6, R8)
        for (int i = 0; i < NV; i++) begin
            run_mul(VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b1);
        end

        // R3: one step of 5 x 3
        start_i = 1'b1; mcand_i = 32'd5; mplier_i = 32'd3;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk(hi_o == 32'h2 && lo_o == 32'h8000_0001, "R3", {hi_o, lo_o}, 64'h0000_0002_8000_0001);
        while (!done_o) @(negedge clk);
        @(negedge clk);

        // R7 and R10: start pulse and operand changes mid-run are ignored
        exp = 64'(32'hDEAD_BEEF) * 64'(32'h0000_1234);
        start_i = 1'b1; mcand_i = 32'hDEAD_BEEF; mplier_i = 32'h0000_1234;
        @(negedge clk);
        start_i = 1'b0;
        k = 1;
        repeat (5) begin @(negedge clk); k++; end
        mcand_i = 32'h1111_1111; mplier_i = 32'h2222_2222;       // R10 stimulus
        @(negedge clk); k++;
        start_i = 1'b1; mcand_i = 32'h7; mplier_i = 32'h9;      // R7 stimulus
        @(negedge clk); k++;
        start_i = 1'b0;
        while (!done_o && k < 100) begin @(negedge clk); k++; end
        chk(k == W + 1, "R7", 64'(k), 64'(W + 1));
        chk({hi_o, lo_o} == exp, "R10", {hi_o, lo_o}, exp);

        // R9: back-to-back, start given in the done cycle
        run_mul(32'hCAFE_0001, 32'h0000_0100, 1'b0);
        run_mul(32'hFFFF_FFFE, 32'hFFFF_FFFD, 1'b1);
        chk(1'b1, "R9", 64'h0, 64'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule